// File: doc/BRIEF.md
# Receive FIFO Almost-Full Flag Generator

This block raises a sticky service-request flag for each of two receive queues, called channel A and channel B. A flag is raised in two cases. The first is when the controller stores a received message into a queue whose occupancy has already reached a shared threshold. The second is when a free-running service timer expires while the queue still holds data. Because of the timer path, a small backlog that never reaches the threshold is still reported to the host after a bounded time.

The queue storage, the reception path and the register decoding sit outside the block. Occupancy counts, store strobes, the threshold and the timer period arrive as ports. The host clears a flag by writing a one to its bit position on a write-one-to-clear port. The timer is a down-counter that reloads from the period input on every expiry. A period of zero switches the timer off.

Top module: `rxq_almost_full_irq`

## Requirements
- R1: A synchronous active-low reset drives both flags to 0 and loads the timer from the period input.
- R2: When a channel's store strobe is high and its occupancy is greater than or equal to the threshold, that channel's flag reads 1 from the next clock cycle.
- R3: Occupancy at or above the threshold without a store strobe does not set the flag.
- R4: A store strobe while occupancy is below the threshold does not set the flag.
- R5: With a nonzero period P, the timer expires once every P cycles. Each expiry sets the flag of every channel whose occupancy is at least 1.
- R6: A timer expiry does not set the flag of a channel whose occupancy is 0.
- R7: A period of 0 disables timer expiries.
- R8: A set flag stays 1 until the host write strobe is high with a 1 in that channel's bit of the write data (bit 0 for channel A, bit 1 for channel B). The flag then reads 0 from the next cycle. A 0 in that bit leaves the flag unchanged.
- R9: When a set condition and a host clear occur in the same cycle, the flag is 1 afterwards.
- R10: The two channels are independent. Events on one channel and clears of one channel's bit do not change the other channel's flag.
- R11: A single threshold input serves both channels, and occupancy exactly equal to the threshold counts as reaching it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wm_level | input | CNT_W | Shared occupancy threshold |
| period_cfg | input | PER_W | Timer reload value; 0 disables the timer |
| a_count | input | CNT_W | Channel A queue occupancy |
| a_wr | input | 1 | Channel A message-store strobe |
| b_count | input | CNT_W | Channel B queue occupancy |
| b_wr | input | 1 | Channel B message-store strobe |
| host_wr | input | 1 | Host write strobe for flag clearing |
| host_wdata | input | 2 | Write-one-to-clear bits (bit 0 = A, bit 1 = B) |
| flag_a | output | 1 | Channel A almost-full flag |
| flag_b | output | 1 | Channel B almost-full flag |

## Verification
Several rules are checked by assertions on every cycle, for both channels:
- a threshold hit on a store sets the flag, even when a clear arrives in the same cycle;
- a timer expiry with data present sets the flag;
- a flag holds unless its clear bit is written;
- a clear with no competing cause drops the flag;
- a flag never rises without a cause;
- no expiry occurs while the period is zero.

The exact spacing of expiries and the behaviour after the period is changed while the block runs cannot be seen from a single cycle. The bench's scenarios show these by timing successive flag rises and by watching a long idle window with the period set to zero.

// File: rtl/rxq_wm_pkg.sv
// Shared constants for the receive-queue almost-full flag generator.
// Assumes exactly two channels, with A at index 0 and B at index 1.
package rxq_wm_pkg;
    localparam int unsigned NCH  = 2;
    localparam int unsigned CH_A = 0;
    localparam int unsigned CH_B = 1;
endpackage

// File: rtl/rxq_period_timer.sv
// Service timer: a down-counter reloaded from period_cfg.
// It gives a one-cycle tick every period_cfg cycles. A period of 0 holds
// the counter at 0 and gives no ticks. Assumes period_cfg is quasi-static;
// a change takes effect at the next reload, or at once when the count is
// at or below 1.
module rxq_period_timer #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_cfg,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    // Expiry when enabled and the count has run down to its last cycle.
    always_comb begin
        tick = (period_cfg != '0) && (cnt_q <= PER_W'(1));
    end

    // Count down, reload on expiry, park at 0 while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= period_cfg;
        end else if (period_cfg == '0) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= period_cfg;
        end else begin
            cnt_q <= cnt_q - PER_W'(1);
        end
    end
endmodule

// File: rtl/rxq_wm_flag.sv
// One channel's sticky almost-full flag.
// The flag sets when a store hits the threshold, or when a timer tick
// finds the queue non-empty. It clears on a host write-one. Set beats
// clear. Assumes count is the occupancy seen in the cycle of the store.
module rxq_wm_flag #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             wr,
    input  logic [CNT_W-1:0] wm,
    input  logic             tick,
    input  logic             clr,
    output logic             flag
);
    logic wm_hit;
    logic tmr_hit;
    logic set_evt;

    // Decode the two independent set causes.
    always_comb begin
        wm_hit  = wr && (count >= wm);
        tmr_hit = tick && (count != '0);
        set_evt = wm_hit || tmr_hit;
    end

    // Sticky flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_almost_full_irq.sv
// Top: two sticky almost-full flags sharing one threshold and one timer.
// Assumes the occupancy counts and store strobes come from the queue
// logic in the same clock domain, and that host_wr is a one-cycle strobe.
module rxq_almost_full_irq
    import rxq_wm_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wm_level,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] a_count,
    input  logic             a_wr,
    input  logic [CNT_W-1:0] b_count,
    input  logic             b_wr,
    input  logic             host_wr,
    input  logic [1:0]       host_wdata,
    output logic             flag_a,
    output logic             flag_b
);
    logic                      tmr_tick;
    logic [NCH-1:0]            wr_v;
    logic [NCH-1:0]            clr_v;
    logic [NCH-1:0]            flag_v;
    logic [NCH-1:0][CNT_W-1:0] cnt_v;

    // Gather per-channel inputs into indexed vectors.
    always_comb begin
        wr_v[CH_A]  = a_wr;
        wr_v[CH_B]  = b_wr;
        cnt_v[CH_A] = a_count;
        cnt_v[CH_B] = b_count;
        clr_v       = host_wr ? host_wdata : '0;
    end

    rxq_period_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_cfg (period_cfg),
        .tick       (tmr_tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        rxq_wm_flag #(.CNT_W(CNT_W)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .count (cnt_v[ch]),
            .wr    (wr_v[ch]),
            .wm    (wm_level),
            .tick  (tmr_tick),
            .clr   (clr_v[ch]),
            .flag  (flag_v[ch])
        );
    end

    // Drive the named flag outputs.
    always_comb begin
        flag_a = flag_v[CH_A];
        flag_b = flag_v[CH_B];
    end
endmodule

// File: rtl/rxq_almost_full_irq_chk.sv
// Checker for rxq_almost_full_irq, bound to every instance of the top.
// It observes the ports and the internal timer tick.
module rxq_almost_full_irq_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned PER_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] wm_level,
    input logic [PER_W-1:0] period_cfg,
    input logic [CNT_W-1:0] a_count,
    input logic             a_wr,
    input logic [CNT_W-1:0] b_count,
    input logic             b_wr,
    input logic             host_wr,
    input logic [1:0]       host_wdata,
    input logic             flag_a,
    input logic             flag_b,
    input logic             tmr_tick
);
    logic [1:0]            wr_c;
    logic [1:0]            flg_c;
    logic [1:0][CNT_W-1:0] cnt_c;

    always_comb begin
        wr_c  = {b_wr, a_wr};
        flg_c = {flag_b, flag_a};
        cnt_c = {b_count, a_count};
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!flag_a && !flag_b));

    // R7
    timer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_cfg == '0) |-> !tmr_tick);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chk
        // R2 R9
        wm_store_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_c[ch] && (cnt_c[ch] >= wm_level)) |=> flg_c[ch]);

        // R5
        tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_tick && (cnt_c[ch] != '0)) |=> flg_c[ch]);

        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_c[ch] && !(host_wr && host_wdata[ch])) |=> flg_c[ch]);

        // R8
        w1c_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_c[ch] && host_wr && host_wdata[ch]
             && !(wr_c[ch] && (cnt_c[ch] >= wm_level))
             && !(tmr_tick && (cnt_c[ch] != '0))) |=> !flg_c[ch]);

        // R3 R4 R6
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flg_c[ch]
             && !(wr_c[ch] && (cnt_c[ch] >= wm_level))
             && !(tmr_tick && (cnt_c[ch] != '0))) |=> !flg_c[ch]);
    end
endmodule

bind rxq_almost_full_irq rxq_almost_full_irq_chk #(
    .CNT_W(CNT_W),
    .PER_W(PER_W)
) u_chk (.*);

// File: tb/rxq_almost_full_irq_bench.sv
// Directed bench for rxq_almost_full_irq: one task per scenario.
module rxq_almost_full_irq_bench;
    localparam int CNT_W = 8;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] wm_level = '0;
    logic [PER_W-1:0] period_cfg = '0;
    logic [CNT_W-1:0] a_count = '0;
    logic             a_wr = 1'b0;
    logic [CNT_W-1:0] b_count = '0;
    logic             b_wr = 1'b0;
    logic             host_wr = 1'b0;
    logic [1:0]       host_wdata = '0;
    logic             flag_a;
    logic             flag_b;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;

    rxq_almost_full_irq #(.CNT_W(CNT_W), .PER_W(PER_W)) u_rxq_almost_full_irq (
        .clk(clk), .rst_n(rst_n), .wm_level(wm_level), .period_cfg(period_cfg),
        .a_count(a_count), .a_wr(a_wr), .b_count(b_count), .b_wr(b_wr),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .flag_a(flag_a), .flag_b(flag_b)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(); @(posedge clk); #1; endtask

    task automatic clear_bits(logic [1:0] bits);
        @(negedge clk); host_wr = 1'b1; host_wdata = bits;
        settle();
        @(negedge clk); host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic t_reset();
        repeat (3) settle();
        @(negedge clk); rst_n = 1'b1;
        settle();
        check("R1 flag_a after reset", flag_a, 0);
        check("R1 flag_b after reset", flag_b, 0);
    endtask

    task automatic t_store_hit();
        @(negedge clk); wm_level = 8'd5; a_count = 8'd5; a_wr = 1'b1;
        settle();
        @(negedge clk); a_wr = 1'b0;
        check("R2 R11 flag_a on store at threshold", flag_a, 1);
        check("R10 flag_b untouched by channel A", flag_b, 0);
        clear_bits(2'b01);
        @(negedge clk); b_count = 8'd200; b_wr = 1'b1;
        settle();
        @(negedge clk); b_wr = 1'b0; b_count = '0;
        check("R2 flag_b on store above threshold", flag_b, 1);
        check("R10 flag_a untouched by channel B", flag_a, 0);
        clear_bits(2'b10);
    endtask

    task automatic t_no_store();
        @(negedge clk); a_count = 8'd9;
        repeat (10) settle();
        check("R3 no set without store", flag_a, 0);
        @(negedge clk); a_count = 8'd4; a_wr = 1'b1;
        settle();
        @(negedge clk); a_wr = 1'b0;
        check("R4 no set on store below threshold", flag_a, 0);
    endtask

    task automatic t_sticky();
        @(negedge clk); a_count = 8'd6; a_wr = 1'b1;
        settle();
        @(negedge clk); a_wr = 1'b0;
        repeat (5) settle();
        check("R8 flag_a holds", flag_a, 1);
        clear_bits(2'b00);
        check("R8 zero write no effect", flag_a, 1);
        clear_bits(2'b10);
        check("R10 clearing B keeps A", flag_a, 1);
        clear_bits(2'b01);
        check("R8 w1c clears flag_a", flag_a, 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk); a_wr = 1'b1; host_wr = 1'b1; host_wdata = 2'b01;
        settle();
        @(negedge clk); a_wr = 1'b0; host_wr = 1'b0; host_wdata = '0;
        check("R9 set beats clear", flag_a, 1);
        clear_bits(2'b01);
        check("R9 later clear works", flag_a, 0);
    endtask

    task automatic wait_rise_b(output int at);
        at = -1;
        for (int i = 0; i < 200; i++) begin
            settle();
            if (flag_b) begin at = cyc; break; end
        end
    endtask

    task automatic t_timer();
        int r0;
        int r1;
        @(negedge clk); a_count = '0; b_count = 8'd1; period_cfg = 16'd12;
        wait_rise_b(r0);
        clear_bits(2'b10);
        wait_rise_b(r1);
        check("R5 expiry spacing equals period", r1 - r0, 12);
        check("R6 empty channel A not set by timer", flag_a, 0);
        @(negedge clk); period_cfg = '0;
        clear_bits(2'b10);
        repeat (40) settle();
        check("R7 period zero gives no expiry", flag_b, 0);
    endtask

    initial begin
        t_reset();
        t_store_hit();
        t_no_store();
        t_sticky();
        t_set_wins();
        t_timer();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule